// File: doc/BRIEF.md
# Level-Priority Interrupt Controller

This block gathers interrupt requests from a set of peripheral sources and chooses one of them for the processor. Each source owns a small control register that holds a priority level, a service-select bit and an enable bit. A request flag is set by a one-cycle event pulse from the source and stays set until software clears it. Of all sources that are both pending and enabled, the one with the numerically lowest level wins. Among winners of equal level, the lowest source index wins.

The winner is presented as an interrupt number, its level, its service-select bit and the address of its three-byte vector. Source k gets interrupt number 11+k. The vector for number n starts at 0xFFFFFC − 4·n. The block also decides whether the processor should take the interrupt. It compares the winner's level with the processor's current level mask and its global enable. All of these outputs are combinational from the registered flags, so they follow every cycle.

Software reaches the per-source registers through a plain write strobe with an address. Read data is combinational for the addressed source.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: A one-cycle pulse on `src_evt[k]` sets the pending flag of source k at that clock edge. The flag then stays set for as long as it is not cleared.
- R2: A write to address k with bit LVL_W+2 of the write data at 1 clears the pending flag of source k. When an event for k arrives in the same cycle, the flag stays set.
- R3: Only sources that are pending and enabled take part in the selection. When there are none, `irq_valid` is 0, and `irq_level`, `irq_num`, `irq_svc` and `irq_vector` are all 0.
- R4: The winner is the participating source with the numerically smallest level.
- R5: When several participants share the smallest level, the lowest source index wins.
- R6: `irq_num` equals 11 plus the winning source index.
- R7: `irq_accept` is 1 exactly when `irq_valid` is 1, `cpu_gie` is 1 and `irq_level` is strictly less than `cpu_mask`. As a result, level 7 is never accepted.
- R8: `irq_vector` equals 0xFFFFFC minus 4·`irq_num` (24 bits) while `irq_valid` is 1.
- R9: A write to address k loads the following fields of source k: level from write bits [LVL_W-1:0], service-select from bit LVL_W, and enable from bit LVL_W+1. Reading address k returns the same three fields at the same positions, with the pending flag at bit LVL_W+2. `irq_svc` carries the winner's service-select bit.
- R10: While `rst_n` is low, every flag and field is 0. As a result, `irq_valid`, `irq_accept` and `reg_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | NUM_SRC | One-cycle event pulse per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Source index for write and read |
| reg_wdata | input | LVL_W+3 | Write data: level, service-select, enable, clear |
| reg_rdata | output | LVL_W+3 | Read data: level, service-select, enable, pending |
| cpu_mask | input | LVL_W | Processor's current interrupt level mask |
| cpu_gie | input | 1 | Processor's global interrupt enable |
| irq_valid | output | 1 | A pending enabled source exists |
| irq_level | output | LVL_W | Level of the winner |
| irq_num | output | 8 | Interrupt number of the winner |
| irq_svc | output | 1 | Service-select bit of the winner |
| irq_accept | output | 1 | The processor should take the interrupt |
| irq_vector | output | 24 | Start address of the winner's vector |

## Verification
A directed phase first tries a single request, which pins down the number and vector mapping. It then adds a pending but disabled source, which shows that the enable gate matters. Next come two sources at different levels, which separate level order from index order. Two sources at equal level then isolate the tie rule. The mask is swept across the winner's level to catch an off-by-one between "less" and "less or equal". A clear that coincides with an event exposes a wrong precedence. A long random phase follows, with sparse events, reconfiguration, clears and changing mask and enable. On every clock it compares all outputs and the read data against a behavioural model, which exercises crowded mixes of levels and indices that the directed cases do not reach.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

  localparam int NUM_W = 8;
  localparam int VEC_W = 24;
  localparam logic [VEC_W-1:0] VEC_TOP = 24'hFFFFFC;

  // Each interrupt number owns a 4-byte slot, counted downward from VEC_TOP.
  function automatic logic [VEC_W-1:0] vector_of(input logic [NUM_W-1:0] num);
    return VEC_TOP - {{(VEC_W-NUM_W-2){1'b0}}, num, 2'b00};
  endfunction

  function automatic logic [NUM_W-1:0] number_of(input logic [NUM_W-1:0] first,
                                                 input logic [NUM_W-1:0] idx);
    return first + idx;
  endfunction

  // Strictly-below test used for acceptance.
  function automatic logic level_passes(input logic [7:0] lvl, input logic [7:0] mask);
    return lvl < mask;
  endfunction

endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             wr_sel,
  input  logic [LVL_W+2:0] wdata,
  output logic [LVL_W-1:0] lvl_o,
  output logic             svc_o,
  output logic             en_o,
  output logic             pend_o
);

  localparam int SVC_B = LVL_W;
  localparam int EN_B  = LVL_W + 1;
  localparam int CLR_B = LVL_W + 2;

  logic clr_hit;
  assign clr_hit = wr_sel & wdata[CLR_B];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_o <= '0;
      svc_o <= 1'b0;
      en_o  <= 1'b0;
    end else if (wr_sel) begin
      lvl_o <= wdata[LVL_W-1:0];
      svc_o <= wdata[SVC_B];
      en_o  <= wdata[EN_B];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_o <= 1'b0;
    else if (evt)     pend_o <= 1'b1;
    else if (clr_hit) pend_o <= 1'b0;
  end

  assert_event_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> pend_o);
  assert_flag_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !clr_hit) |=> pend_o);
  assert_clear_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !evt) |=> !pend_o);
  assert_no_spurious_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_o && !evt) |=> !pend_o);

endmodule

// File: rtl/irq_pick_tree.sv
module irq_pick_tree #(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3,
  parameter int IDX_W   = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SRC-1:0]            req,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl,
  output logic                          valid,
  output logic [IDX_W-1:0]              win_idx,
  output logic [LVL_W-1:0]              win_lvl
);

  // Ascending scan with a strict compare: the lowest index keeps a tie.
  always_comb begin
    valid   = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (req[k] && (!valid || lvl[k] < win_lvl)) begin
        valid   = 1'b1;
        win_idx = IDX_W'(k);
        win_lvl = lvl[k];
      end
    end
  end

  assert_valid_has_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> req[win_idx]);
  assert_idle_when_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> !valid);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
    assert_no_better_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && req[g]) |-> (lvl[g] >= win_lvl));
    assert_tie_low_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && req[g] && lvl[g] == win_lvl) |-> (IDX_W'(g) >= win_idx));
  end

endmodule

// File: rtl/irq_cpu_gate.sv
module irq_cpu_gate
  import lvl_irq_pkg::*;
#(
  parameter int LVL_W     = 3,
  parameter int IDX_W     = 3,
  parameter int FIRST_NUM = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [IDX_W-1:0]  win_idx,
  input  logic [LVL_W-1:0]  win_lvl,
  input  logic [LVL_W-1:0]  cpu_mask,
  input  logic              cpu_gie,
  output logic              accept,
  output logic [NUM_W-1:0]  num,
  output logic [VEC_W-1:0]  vector
);

  logic [NUM_W-1:0] raw_num;
  logic             lvl_ok;

  assign raw_num = number_of(NUM_W'(FIRST_NUM), NUM_W'(win_idx));
  assign lvl_ok  = level_passes(8'(win_lvl), 8'(cpu_mask));
  assign accept  = valid & cpu_gie & lvl_ok;
  assign num     = valid ? raw_num : '0;
  assign vector  = valid ? vector_of(raw_num) : '0;

  assert_top_level_never_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_lvl == {LVL_W{1'b1}}) |-> !accept);
  assert_vector_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (vector[1:0] == 2'b00 && vector != '0));
  assert_gie_gates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_gie |-> !accept);

endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
#(
  parameter int NUM_SRC   = 8,
  parameter int LVL_W     = 3,
  parameter int FIRST_NUM = 11,
  localparam int IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int ADDR_W   = IDX_W,
  localparam int REG_W    = LVL_W + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_evt,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic [LVL_W-1:0]   cpu_mask,
  input  logic               cpu_gie,
  output logic               irq_valid,
  output logic [LVL_W-1:0]   irq_level,
  output logic [7:0]         irq_num,
  output logic               irq_svc,
  output logic               irq_accept,
  output logic [23:0]        irq_vector
);

  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q;
  logic [NUM_SRC-1:0]            svc_q;
  logic [NUM_SRC-1:0]            en_q;
  logic [NUM_SRC-1:0]            pend_q;
  logic [NUM_SRC-1:0]            req;
  logic [NUM_SRC-1:0][REG_W-1:0] view;
  logic                          pick_valid;
  logic [IDX_W-1:0]              pick_idx;
  logic [LVL_W-1:0]              pick_lvl;
  logic                          addr_in_range;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
    logic wr_hit;
    assign wr_hit = reg_we && (reg_addr == ADDR_W'(g));

    irq_src_slot #(.LVL_W(LVL_W)) i_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (src_evt[g]),
      .wr_sel (wr_hit),
      .wdata  (reg_wdata),
      .lvl_o  (lvl_q[g]),
      .svc_o  (svc_q[g]),
      .en_o   (en_q[g]),
      .pend_o (pend_q[g])
    );

    assign req[g]  = pend_q[g] & en_q[g];
    assign view[g] = {pend_q[g], en_q[g], svc_q[g], lvl_q[g]};
  end

  assign addr_in_range = ({1'b0, reg_addr} < (ADDR_W+1)'(NUM_SRC));
  assign reg_rdata     = addr_in_range ? view[reg_addr] : '0;

  irq_pick_tree #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) i_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .lvl     (lvl_q),
    .valid   (pick_valid),
    .win_idx (pick_idx),
    .win_lvl (pick_lvl)
  );

  irq_cpu_gate #(.LVL_W(LVL_W), .IDX_W(IDX_W), .FIRST_NUM(FIRST_NUM)) i_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (pick_valid),
    .win_idx  (pick_idx),
    .win_lvl  (pick_lvl),
    .cpu_mask (cpu_mask),
    .cpu_gie  (cpu_gie),
    .accept   (irq_accept),
    .num      (irq_num),
    .vector   (irq_vector)
  );

  assign irq_valid = pick_valid;
  assign irq_level = pick_valid ? pick_lvl : '0;
  assign irq_svc   = pick_valid ? svc_q[pick_idx] : 1'b0;

  assert_accept_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_accept |-> (irq_valid && irq_level < cpu_mask));
  assert_idle_outputs_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> (irq_num == '0 && irq_vector == '0 && !irq_svc));

endmodule

// File: tb/test_lvl_irq_ctrl.sv
module test_lvl_irq_ctrl;

  localparam int N  = 8;
  localparam int LW = 3;
  localparam int RW = LW + 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_evt = '0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [RW-1:0] reg_wdata = '0;
  logic [RW-1:0] reg_rdata;
  logic [LW-1:0] cpu_mask = '0;
  logic          cpu_gie = 1'b0;
  logic          irq_valid;
  logic [LW-1:0] irq_level;
  logic [7:0]    irq_num;
  logic          irq_svc;
  logic          irq_accept;
  logic [23:0]   irq_vector;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  lvl_irq_ctrl i_lvl_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_mask(cpu_mask), .cpu_gie(cpu_gie), .irq_valid(irq_valid),
    .irq_level(irq_level), .irq_num(irq_num), .irq_svc(irq_svc),
    .irq_accept(irq_accept), .irq_vector(irq_vector)
  );

  // Behavioural reference state.
  int m_lvl [N];
  bit m_svc [N];
  bit m_en  [N];
  bit m_pend[N];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) begin
        m_lvl[k] <= 0; m_svc[k] <= 0; m_en[k] <= 0; m_pend[k] <= 0;
      end
    end else begin
      for (int k = 0; k < N; k++) begin
        if (reg_we && int'(reg_addr) == k) begin
          m_lvl[k] <= int'(reg_wdata[2:0]);
          m_svc[k] <= reg_wdata[3];
          m_en[k]  <= reg_wdata[4];
        end
        if (src_evt[k])                                   m_pend[k] <= 1'b1;
        else if (reg_we && int'(reg_addr) == k && reg_wdata[5]) m_pend[k] <= 1'b0;
      end
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_out(output bit v, output int num, output int lvl,
                           output bit svc, output bit acc, output int vec);
    int cand[$];
    int best;
    for (int k = 0; k < N; k++) if (m_pend[k] && m_en[k]) cand.push_back(k);
    v = (cand.size() > 0);
    num = 0; lvl = 0; svc = 0; acc = 0; vec = 0;
    if (v) begin
      best = cand[0];
      foreach (cand[i]) if (m_lvl[cand[i]] < m_lvl[best]) best = cand[i];
      num = best + 11;
      lvl = m_lvl[best];
      svc = m_svc[best];
      acc = cpu_gie && (lvl < int'(cpu_mask));
      vec = 'hFFFFFC - num * 4;
    end
  endtask

  // Per-cycle comparison, 5 ns after each rising edge.
  always @(posedge clk) begin
    bit v, s, a;
    int n, l, vc, rd;
    #5;
    if (rst_n && !done) begin
      model_out(v, n, l, s, a, vc);
      rd = (int'(m_pend[reg_addr]) << 5) | (int'(m_en[reg_addr]) << 4) |
           (int'(m_svc[reg_addr]) << 3) | m_lvl[reg_addr];
      check("R3",    "valid",  irq_valid,        v);
      check("R4 R5", "level",  irq_level,        l);
      check("R6",    "num",    irq_num,          n);
      check("R7",    "accept", irq_accept,       a);
      check("R8",    "vector", irq_vector,       vc);
      check("R9",    "svc",    irq_svc,          s);
      check("R1 R2 R9", "rdata", reg_rdata,      rd);
    end
  end

  task automatic wr(input int addr, input int lvl, input bit svc, input bit en, input bit clr);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(addr);
    reg_wdata = {clr, en, svc, 3'(lvl)};
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
    #1;
  endtask

  task automatic pulse(input int k);
    @(negedge clk);
    src_evt[k] = 1'b1;
    @(negedge clk);
    src_evt = '0;
    #1;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    src_evt = '1;
    #1;
    check("R10", "valid in reset",  irq_valid,  0);
    check("R10", "accept in reset", irq_accept, 0);
    check("R10", "rdata in reset",  reg_rdata,  0);
    @(negedge clk);
    src_evt = '0;
    rst_n = 1'b1;
    cpu_mask = 3'd7; cpu_gie = 1'b1;
    @(negedge clk); #1;
    check("R10", "valid after reset", irq_valid, 0);

    wr(2, 3, 0, 1, 0);
    pulse(2);
    check("R1", "valid after event", irq_valid, 1);
    check("R6", "num src2", irq_num, 13);
    check("R8", "vector src2", irq_vector, 'hFFFFC8);
    check("R7", "accept lvl3 mask7", irq_accept, 1);

    pulse(4);
    check("R3", "disabled src4 ignored", irq_num, 13);
    reg_addr = 3'd4; #1;
    check("R9", "rdata src4 pending", reg_rdata, 6'b100000);

    wr(4, 5, 0, 1, 0);
    check("R4", "lvl3 beats lvl5", irq_num, 13);
    wr(4, 1, 0, 1, 0);
    check("R4", "lvl1 beats lvl3", irq_num, 15);

    wr(1, 1, 0, 1, 0);
    pulse(1);
    check("R5", "tie goes to src1", irq_num, 12);

    cpu_mask = 3'd1; #1;
    check("R7", "level equal mask refused", irq_accept, 0);
    cpu_mask = 3'd2; #1;
    check("R7", "level below mask taken", irq_accept, 1);
    cpu_gie = 1'b0; #1;
    check("R7", "gie off refused", irq_accept, 0);
    cpu_gie = 1'b1; cpu_mask = 3'd7;

    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = {1'b1, 1'b1, 1'b0, 3'd1};
    src_evt[1] = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0; src_evt = '0; #1;
    check("R2", "event beats clear", irq_num, 12);
    wr(1, 1, 0, 1, 1);
    check("R2", "clear src1", irq_num, 15);
    wr(4, 1, 0, 1, 1);
    wr(2, 3, 0, 1, 1);
    check("R3", "none pending", irq_valid, 0);
    check("R3", "num zero idle", irq_num, 0);

    wr(3, 7, 1, 1, 0);
    pulse(3);
    check("R7", "level 7 refused", irq_accept, 0);
    check("R9", "svc of winner", irq_svc, 1);
    repeat (5) @(negedge clk);
    #1;
    check("R1", "flag held", irq_num, 14);

    // Random phase: compared every cycle by the model.
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      for (int k = 0; k < N; k++) src_evt[k] = ($urandom_range(0, 19) == 0);
      reg_we    = ($urandom_range(0, 3) == 0);
      reg_addr  = 3'($urandom_range(0, N-1));
      reg_wdata = RW'($urandom_range(0, 63));
      if ($urandom_range(0, 7) == 0) cpu_mask = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 15) == 0) cpu_gie = ~cpu_gie;
    end
    @(negedge clk);
    src_evt = '0; reg_we = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule